// File: doc/BRIEF.md
# Internal Data Memory Access Unit

This block sits between an 8-bit microcontroller core and its on-chip data storage. It owns a 256-byte RAM and forwards some accesses to a separate bank of special function registers (SFRs) through a dedicated port. The core presents one request per cycle: an 8-bit address, an access mode, a write flag, write data and a valid strobe. The block decides whether the request lands in RAM or on the SFR port, and it returns read data one clock later with a valid strobe.

The upper half of the address range, 80h to FFh, is shared by two separate storages, and the access mode chooses between them. A direct access there reaches the SFR port. An indirect access there reaches the upper 128 bytes of RAM. Working registers R0 to R7 live in the bottom 32 bytes of RAM as four banks of eight. The core's two bank-select bits pick the bank, and the register number picks the byte within it.

An indirect access takes two steps. First the block reads the pointer from R0 or R1 of the current bank. Then it accesses the byte the pointer names. During the second step it raises `busy`, and the core holds off.

Top module: `idm_access_unit`

## Requirements
- R1: A direct access (mode 2'b00) with address bit 7 clear reads or writes the lower RAM byte at that address. A write takes effect at the clock edge where the strobe is accepted. A read returns its data with `rd_valid` high in the cycle after acceptance.
- R2: A direct access with address bit 7 set goes only to the SFR port. For a write, `sfr_we` is high for that cycle, with `sfr_addr` equal to the request address and `sfr_wdata` equal to the write data. For a read, `sfr_rd` is high and the `sfr_rdata` value is returned with `rd_valid` one cycle later. No RAM byte is written.
- R3: An indirect access (mode 2'b01) whose pointer is 80h or above reads or writes the upper RAM byte, never the SFR port. A direct read of the same address still returns SFR data.
- R4: A register access (mode 2'b10) with register number n (address bits 2:0) reaches the RAM byte {3'b000, reg_bank[1], reg_bank[0], n}. Here `reg_bank[1]` is the status word's bit 4 and `reg_bank[0]` is its bit 3.
- R5: A change of `reg_bank` applies to the very next accepted access, including a register access issued in the cycle right after one that used another bank.
- R6: An indirect access takes its pointer from R0 of the current bank when address bit 0 is 0, and from R1 when it is 1.
- R7: After an indirect access is accepted, `busy` is high for exactly one cycle. Any request presented during that cycle is ignored. An indirect read returns data two cycles after acceptance. An indirect write lands at the end of the busy cycle.
- R8: An indirect access whose pointer is below 80h reaches the same lower RAM byte that a direct access to that address reaches.
- R9: After reset, `busy`, `rd_valid`, `sfr_we` and `sfr_rd` are low. `rd_valid` is raised only for reads, once per accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_bank | input | 2 | Bank-select field of the core status word (bit 1 = status bit 4, bit 0 = status bit 3) |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_mode | input | 2 | 00 direct, 01 indirect, 10 register, 11 no access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Direct address, register number in bits 2:0, or R0/R1 select in bit 0 |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Second step of an indirect access in progress |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| sfr_addr | output | 8 | SFR port address |
| sfr_we | output | 1 | SFR write strobe |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid in the cycle `sfr_rd` is high |

## Verification
The embedded properties check, on every cycle, the rules that hold for a single cycle or a pair of cycles. SFR strobes never coincide with a RAM write. They appear only for direct requests at 80h or above, and never while `busy` is high. `busy` never lasts more than one cycle and always follows an accepted indirect request. `rd_valid` always follows a read. Address resolution can only be shown by the bench scenarios: the effect of bank bits on register and pointer lookups, the separation of upper RAM from the SFR space, and ignored requests during the busy cycle. In those scenarios, data is written by one mode and read back by another.

// File: rtl/idm_pkg.sv
package idm_pkg;

  typedef enum logic [1:0] {
    MODE_DIR = 2'b00,
    MODE_IND = 2'b01,
    MODE_REG = 2'b10,
    MODE_NOP = 2'b11
  } acc_mode_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_TGT  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/idm_rst_sync.sv
module idm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/idm_route.sv
module idm_route
  import idm_pkg::*;
#(
  parameter int AW     = 8,
  parameter int REG_W  = 3,
  parameter int BANK_W = 2
) (
  input  acc_mode_e         mode,
  input  logic [AW-1:0]     addr,
  input  logic [BANK_W-1:0] bank,
  output logic              ram_sel,
  output logic              sfr_sel,
  output logic              ptr_fetch,
  output logic [AW-1:0]     phys_addr
);

  localparam int PAD_W = AW - BANK_W - REG_W;

  logic [AW-1:0] reg_phys;
  logic [AW-1:0] ptr_phys;

  // working register n of the selected bank
  assign reg_phys = {{PAD_W{1'b0}}, bank, addr[REG_W-1:0]};
  // R0 or R1 of the selected bank, picked by address bit 0
  assign ptr_phys = {{PAD_W{1'b0}}, bank, {(REG_W-1){1'b0}}, addr[0]};

  always_comb begin
    ram_sel   = 1'b0;
    sfr_sel   = 1'b0;
    ptr_fetch = 1'b0;
    phys_addr = addr;
    unique case (mode)
      MODE_DIR: begin
        sfr_sel   = addr[AW-1];
        ram_sel   = !addr[AW-1];
        phys_addr = addr;
      end
      MODE_REG: begin
        ram_sel   = 1'b1;
        phys_addr = reg_phys;
      end
      MODE_IND: begin
        ram_sel   = 1'b1;
        ptr_fetch = 1'b1;
        phys_addr = ptr_phys;
      end
      default: begin
        ram_sel   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/idm_seq.sv
module idm_seq
  import idm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_in,
  input  logic [DW-1:0] wdata_in,
  output logic          tgt_phase,
  output logic          lat_wr,
  output logic [DW-1:0] lat_wdata
);

  seq_state_e    state_q, state_d;
  logic          wr_q;
  logic [DW-1:0] wdata_q;
  logic          cap_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (start) state_d = SEQ_TGT;
      SEQ_TGT:  state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  assign cap_en = (state_q == SEQ_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (cap_en) begin
      wr_q    <= wr_in;
      wdata_q <= wdata_in;
    end
  end

  assign tgt_phase = (state_q == SEQ_TGT);
  assign lat_wr    = wr_q;
  assign lat_wdata = wdata_q;

  p_tgt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_phase |=> !tgt_phase);

endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (en && !we) q <= mem[addr];
  end

  assign rdata = q;

endmodule

// File: rtl/idm_access_unit.sv
module idm_access_unit
  import idm_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter int REG_W  = 3,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] reg_bank,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [AW-1:0]     sfr_addr,
  output logic              sfr_we,
  output logic              sfr_rd,
  output logic [DW-1:0]     sfr_wdata,
  input  logic [DW-1:0]     sfr_rdata
);

  logic          rst_s;
  acc_mode_e     mode;
  logic          accept;
  logic          ram_sel, sfr_sel, ptr_fetch;
  logic [AW-1:0] phys_addr;
  logic          tgt_phase, lat_wr;
  logic [DW-1:0] lat_wdata;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_q;
  logic          rd_issue, rd_from_sfr;
  logic          pend_q, pend_d;
  logic          src_q, src_d;
  logic [DW-1:0] sfr_cap_q;

  idm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  assign mode   = acc_mode_e'(req_mode);
  assign accept = req_valid && !tgt_phase;

  idm_route #(.AW(AW), .REG_W(REG_W), .BANK_W(BANK_W)) u_route (
    .mode(mode), .addr(req_addr), .bank(reg_bank),
    .ram_sel(ram_sel), .sfr_sel(sfr_sel), .ptr_fetch(ptr_fetch),
    .phys_addr(phys_addr)
  );

  idm_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(accept && ptr_fetch),
    .wr_in(req_write), .wdata_in(req_wdata),
    .tgt_phase(tgt_phase), .lat_wr(lat_wr), .lat_wdata(lat_wdata)
  );

  // RAM port: second step of an indirect access uses the fetched pointer
  always_comb begin
    if (tgt_phase) begin
      ram_en    = 1'b1;
      ram_we    = lat_wr;
      ram_addr  = ram_q[AW-1:0];
      ram_wdata = lat_wdata;
    end else begin
      ram_en    = accept && ram_sel;
      ram_we    = accept && ram_sel && !ptr_fetch && req_write;
      ram_addr  = phys_addr;
      ram_wdata = req_wdata;
    end
  end

  idm_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_q)
  );

  // SFR port, driven only for direct accesses in the upper range
  assign sfr_we    = accept && sfr_sel && req_write;
  assign sfr_rd    = accept && sfr_sel && !req_write;
  assign sfr_addr  = sfr_sel ? req_addr  : '0;
  assign sfr_wdata = sfr_sel ? req_wdata : '0;

  // read return pipeline
  assign rd_from_sfr = sfr_rd;
  assign rd_issue    = tgt_phase ? !lat_wr
                                 : (accept && !req_write && !ptr_fetch
                                    && (ram_sel || sfr_sel));

  always_comb begin
    pend_d = rd_issue;
    src_d  = rd_from_sfr;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pend_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      src_q  <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      sfr_cap_q <= '0;
    else if (sfr_rd) sfr_cap_q <= sfr_rdata;
  end

  assign busy     = tgt_phase;
  assign rd_valid = pend_q;
  assign rd_data  = src_q ? sfr_cap_q : ram_q;

  p_sfr_no_ram_write_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (sfr_we || sfr_rd) |-> !ram_we);

  p_sfr_direct_high_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (sfr_we || sfr_rd) |-> (req_mode == 2'b00 && req_addr[AW-1] && !busy));

  p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(busy) |-> $past(req_valid && req_mode == 2'b01));

  p_rdvalid_read_r9: assert property (@(posedge clk) disable iff (!rst_s)
    rd_valid |-> ($past(req_valid && !req_write && !busy) || $past(busy)));

  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({sfr_we, sfr_rd}));

endmodule

// File: tb/sim_idm_access_unit.sv
module sim_idm_access_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_bank;
  logic       req_valid;
  logic [1:0] req_mode;
  logic       req_write;
  logic [7:0] req_addr, req_wdata;
  logic       busy, rd_valid, sfr_we, sfr_rd;
  logic [7:0] rd_data, sfr_addr, sfr_wdata, sfr_rdata;

  int n_vec  = 0;
  int n_fail = 0;
  logic [7:0] model [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         running = 1'b0;

  always #2 clk = ~clk;

  assign sfr_rdata = sfr_addr ^ 8'h5A;

  idm_access_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_bank(reg_bank), .req_valid(req_valid),
    .req_mode(req_mode), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_rd(sfr_rd),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as rd_valid appears
  always @(negedge clk) begin
    if (running && rd_valid) begin
      if (exp_q.size() == 0) chk("R9 unexpected rd_valid", 8'h01, 8'h00);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // driver: one request; ign != 0 presents a direct write to 10h=EE during busy
  task automatic acc(input logic [1:0] m, input logic w, input logic [7:0] a,
                     input logic [7:0] d, input logic [1:0] bk, input string tag,
                     input bit ign = 1'b0);
    logic [7:0] pa;
    @(negedge clk);
    reg_bank = bk; req_valid = 1'b1; req_mode = m; req_write = w;
    req_addr = a; req_wdata = d;
    #1;
    if (m == 2'b00 && a[7]) begin
      chk({tag, " sfr_we"}, {7'd0, sfr_we}, {7'd0, w});
      chk({tag, " sfr_rd"}, {7'd0, sfr_rd}, {7'd0, !w});
      chk({tag, " sfr_addr"}, sfr_addr, a);
      if (w) chk({tag, " sfr_wdata"}, sfr_wdata, d);
      else begin exp_q.push_back(a ^ 8'h5A); tag_q.push_back(tag); end
    end else begin
      chk({tag, " no sfr strobe"}, {6'd0, sfr_we, sfr_rd}, 8'h00);
      if (m == 2'b00) pa = a;
      else if (m == 2'b10) pa = {3'b000, bk, a[2:0]};
      else pa = model[{3'b000, bk, 2'b00, a[0]}];
      if (w) model[pa] = d;
      else begin exp_q.push_back(model[pa]); tag_q.push_back(tag); end
    end
    if (m == 2'b01) begin
      @(negedge clk);
      chk({tag, " R7 busy high"}, {7'd0, busy}, 8'h01);
      if (ign) begin
        req_valid = 1'b1; req_mode = 2'b00; req_write = 1'b1;
        req_addr = 8'h10; req_wdata = 8'hEE;
      end else req_valid = 1'b0;
      #1;
      chk({tag, " R7 no sfr during busy"}, {6'd0, sfr_we, sfr_rd}, 8'h00);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_vec++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_bank = 2'b00; req_valid = 1'b0; req_mode = 2'b00;
    req_write = 1'b0; req_addr = 8'h00; req_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;
    chk("R9 reset busy", {7'd0, busy}, 8'h00);
    chk("R9 reset rd_valid", {7'd0, rd_valid}, 8'h00);
    chk("R9 reset sfr strobes", {6'd0, sfr_we, sfr_rd}, 8'h00);

    // R1 lower RAM, direct
    acc(2'b00, 1, 8'h10, 8'hA1, 2'd0, "R1 wr 10");
    acc(2'b00, 0, 8'h10, 8'h00, 2'd0, "R1 rd 10");
    acc(2'b00, 1, 8'h7F, 8'h3C, 2'd0, "R1 wr 7F");
    acc(2'b00, 0, 8'h7F, 8'h00, 2'd0, "R1 rd 7F");
    // R2 SFR space
    acc(2'b00, 1, 8'h80, 8'h77, 2'd0, "R2 sfr wr 80");
    acc(2'b00, 0, 8'hC5, 8'h00, 2'd0, "R2 sfr rd C5");
    // R4 register mode across banks
    acc(2'b10, 1, 8'h03, 8'h4D, 2'd2, "R4 wr R3 bank2");
    acc(2'b00, 0, 8'h13, 8'h00, 2'd0, "R4 rd 13 direct");
    acc(2'b00, 1, 8'h0B, 8'h9E, 2'd0, "R4 wr 0B direct");
    acc(2'b10, 0, 8'h03, 8'h00, 2'd1, "R4 rd R3 bank1");
    // R5 back-to-back bank change
    acc(2'b10, 1, 8'h00, 8'h11, 2'd3, "R5 wr R0 bank3");
    acc(2'b10, 1, 8'h00, 8'h22, 2'd0, "R5 wr R0 bank0");
    acc(2'b00, 0, 8'h18, 8'h00, 2'd0, "R5 rd 18");
    acc(2'b00, 0, 8'h00, 8'h00, 2'd0, "R5 rd 00");
    // R3/R6/R8 indirect
    acc(2'b10, 1, 8'h00, 8'h90, 2'd0, "R6 set R0 bank0");
    acc(2'b10, 1, 8'h01, 8'h20, 2'd0, "R6 set R1 bank0");
    acc(2'b01, 1, 8'h00, 8'h5D, 2'd0, "R3 ind wr 90");
    acc(2'b00, 0, 8'h90, 8'h00, 2'd0, "R3 direct 90 is sfr");
    acc(2'b01, 0, 8'h00, 8'h00, 2'd0, "R3 ind rd 90");
    acc(2'b00, 1, 8'h20, 8'h6B, 2'd0, "R8 wr 20 direct");
    acc(2'b01, 0, 8'h01, 8'h00, 2'd0, "R8 ind rd via R1");
    acc(2'b01, 1, 8'h01, 8'hC3, 2'd0, "R8 ind wr via R1");
    acc(2'b00, 0, 8'h20, 8'h00, 2'd0, "R8 rd 20 direct");
    acc(2'b10, 1, 8'h00, 8'hFF, 2'd1, "R6 set R0 bank1");
    acc(2'b01, 1, 8'h00, 8'h0F, 2'd1, "R6 ind wr FF bank1");
    acc(2'b01, 0, 8'h00, 8'h00, 2'd0, "R6 ind rd bank0");
    acc(2'b01, 0, 8'h00, 8'h00, 2'd1, "R6 ind rd bank1");
    // R7 request during busy is ignored
    acc(2'b01, 1, 8'h00, 8'h44, 2'd0, "R7 ind wr w/ stray", 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 busy one cycle", {7'd0, busy}, 8'h00);
    acc(2'b00, 0, 8'h10, 8'h00, 2'd0, "R7 stray ignored rd 10");
    acc(2'b01, 0, 8'h00, 8'h00, 2'd0, "R7 ind rd 90");
    idle(6);
    chk("R9 all reads returned", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule